// File: doc/BRIEF.md
# Clock frequency fine-adjust pulser

This block slowly pulls a time-of-day counter faster or slower than its nominal rate. Software programs a correction interval and a unit. While correction is on, the block adds the clock period to an elapsed-time accumulator on every cycle, measured in the selected unit. Each time the accumulated time reaches the interval, the block emits a one-cycle pulse. The time-of-day counter then adds one extra unit, or drops one unit, as the direction output says.

Two registers control the block, and each is written by a strobe and a data word. The control register holds an enable bit and a direction bit. The interval register holds a 30-bit interval and a unit-select bit. A picosecond interval gives fine steps between pulses. A nanosecond interval stretches the spacing a thousandfold, for very small corrections. The block does not turn a ppm figure into an interval; software does that.

Top module: `fadj_pulser`

## Requirements
- R1: After reset the block is disabled, the interval is zero, and both adj_pulse_o and adj_dir_o are 0.
- R2: Control word layout: bit 0 is enable and bit 1 is direction. Writing all zeros disables correction. While disabled, no pulse is produced and the accumulator is held at zero.
- R3: Interval word layout: bits 29:0 are the interval and bit 30 selects the unit (0 = picoseconds, 1 = nanoseconds). The interval is taken as an unsigned value below 2^30.
- R4: In picosecond mode the accumulator grows by CLK_PERIOD_PS each cycle. With an interval of five clock periods, the first pulse appears five cycles after the enabling write, and pulses then repeat every five cycles.
- R5: When the accumulator reaches the interval, the interval is subtracted and the remainder is kept. An interval of 2.5 clock periods gives pulse spacings that alternate between 3 and 2 cycles.
- R6: In nanosecond mode the accumulator grows by CLK_PERIOD_PS/1000 each cycle. With the default period, an interval of 40 gives one pulse every 4 cycles.
- R7: adj_dir_o equals the direction bit (1 = drop one unit, 0 = add one unit) in every cycle where adj_pulse_o is 1. It is 0 in every other cycle.
- R8: Writing either register clears the accumulator and suppresses the pulse at that edge. Rewriting the interval while enabled therefore delays the next pulse to a full interval after the write.
- R9: An interval of zero produces no pulses, even when enabled.
- R10: An interval not larger than one cycle's step produces a pulse on every cycle, and the accumulator always stays below the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 2 | Control word: bit 0 enable, bit 1 direction |
| frq_we_i | input | 1 | Interval register write strobe |
| frq_wdata_i | input | IVAL_W+1 | Interval word: low IVAL_W bits interval, top bit unit |
| adj_pulse_o | output | 1 | One-cycle correction pulse |
| adj_dir_o | output | 1 | Direction for the current pulse: 1 drop, 0 add |

## Verification
A corrupt accumulator shows up at the ports as a shifted pulse phase. The first pulse after a write arrives early or late, within one interval of the write. A lost remainder shows up as pulse counts that drift over a window of a few intervals, which is why every scenario counts pulses over a fixed window and also checks the index of the first pulse. A stale direction or enable bit shows up within one pulse as a wrong direction level, or as pulses that continue after a disabling write.

// File: rtl/fadj_pkg.sv
package fadj_pkg;
  typedef enum logic {
    UNIT_PS = 1'b0,
    UNIT_NS = 1'b1
  } fadj_unit_e;

  localparam int unsigned CFG_EN_BIT  = 0;
  localparam int unsigned CFG_DIR_BIT = 1;
  localparam int unsigned CFG_W       = 2;

  function automatic int unsigned ns_step(input int unsigned period_ps);
    return (period_ps < 1000) ? 1 : period_ps / 1000;
  endfunction
endpackage

// File: rtl/fadj_regs.sv
module fadj_regs
  import fadj_pkg::*;
#(
  parameter int unsigned IVAL_W = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              frq_we_i,
  input  logic [IVAL_W:0]   frq_wdata_i,
  output logic              en_o,
  output logic              dir_o,
  output fadj_unit_e        unit_o,
  output logic [IVAL_W-1:0] ival_o,
  output logic              restart_o
);
  logic              en_q, dir_q;
  fadj_unit_e        unit_q;
  logic [IVAL_W-1:0] ival_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      dir_q <= 1'b0;
    end else if (cfg_we_i) begin
      en_q  <= cfg_wdata_i[CFG_EN_BIT];
      dir_q <= cfg_wdata_i[CFG_DIR_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unit_q <= UNIT_PS;
      ival_q <= '0;
    end else if (frq_we_i) begin
      unit_q <= fadj_unit_e'(frq_wdata_i[IVAL_W]);
      ival_q <= frq_wdata_i[IVAL_W-1:0];
    end
  end

  assign en_o      = en_q;
  assign dir_o     = dir_q;
  assign unit_o    = unit_q;
  assign ival_o    = ival_q;
  assign restart_o = cfg_we_i | frq_we_i;
endmodule

// File: rtl/fadj_accum.sv
module fadj_accum
  import fadj_pkg::*;
#(
  parameter int unsigned IVAL_W        = 30,
  parameter int unsigned CLK_PERIOD_PS = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              restart_i,
  input  fadj_unit_e        unit_i,
  input  logic [IVAL_W-1:0] ival_i,
  output logic              hit_o,
  output logic [IVAL_W:0]   acc_o
);
  localparam int unsigned ACC_W = IVAL_W + 1;
  localparam int unsigned SUM_W = IVAL_W + 2;
  localparam logic [SUM_W-1:0] STEP_PS = SUM_W'(CLK_PERIOD_PS);
  localparam logic [SUM_W-1:0] STEP_NS = SUM_W'(ns_step(CLK_PERIOD_PS));

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0] step, sum, ival_w, rem;
  logic             clr, hit;

  assign step   = (unit_i == UNIT_NS) ? STEP_NS : STEP_PS;
  assign ival_w = SUM_W'(ival_i);
  assign sum    = SUM_W'(acc_q) + step;
  assign rem    = sum - ival_w;
  assign hit    = (ival_i != '0) && (sum >= ival_w);
  assign clr    = restart_i | ~en_i;

  always_comb begin
    acc_d = acc_q;
    if (clr || ival_i == '0) begin
      acc_d = '0;
    end else if (hit) begin
      // an oversized remainder is dropped so the accumulator stays bounded
      acc_d = (rem >= ival_w) ? '0 : rem[ACC_W-1:0];
    end else begin
      acc_d = sum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign hit_o = hit & ~clr;
  assign acc_o = acc_q;
endmodule

// File: rtl/fadj_emit.sv
module fadj_emit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic dir_i,
  output logic pulse_o,
  output logic dir_o
);
  logic pulse_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      pulse_q <= hit_i;
      dir_q   <= hit_i & dir_i;
    end
  end

  assign pulse_o = pulse_q;
  assign dir_o   = dir_q;
endmodule

// File: rtl/fadj_pulser.sv
module fadj_pulser
  import fadj_pkg::*;
#(
  parameter int unsigned IVAL_W        = 30,
  parameter int unsigned CLK_PERIOD_PS = 10000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_wdata_i,
  input  logic             frq_we_i,
  input  logic [IVAL_W:0]  frq_wdata_i,
  output logic             adj_pulse_o,
  output logic             adj_dir_o
);
  logic              en_q, dir_q, restart, hit;
  fadj_unit_e        unit_q;
  logic [IVAL_W-1:0] ival_q;
  logic [IVAL_W:0]   acc_q;

  fadj_regs #(.IVAL_W(IVAL_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .frq_we_i    (frq_we_i),
    .frq_wdata_i (frq_wdata_i),
    .en_o        (en_q),
    .dir_o       (dir_q),
    .unit_o      (unit_q),
    .ival_o      (ival_q),
    .restart_o   (restart)
  );

  fadj_accum #(.IVAL_W(IVAL_W), .CLK_PERIOD_PS(CLK_PERIOD_PS)) u_accum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_q),
    .restart_i (restart),
    .unit_i    (unit_q),
    .ival_i    (ival_q),
    .hit_o     (hit),
    .acc_o     (acc_q)
  );

  fadj_emit u_emit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .dir_i   (dir_q),
    .pulse_o (adj_pulse_o),
    .dir_o   (adj_dir_o)
  );
endmodule

// File: rtl/fadj_pulser_chk.sv
module fadj_pulser_chk #(
  parameter int unsigned IVAL_W = 30
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              frq_we_i,
  input logic              adj_pulse_o,
  input logic              adj_dir_o,
  input logic              en_i,
  input logic [IVAL_W-1:0] ival_i,
  input logic [IVAL_W:0]   acc_i
);
  assert_pulse_needs_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_pulse_o |-> en_i);

  assert_idle_acc_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (acc_i == '0));

  assert_dir_only_with_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adj_pulse_o |-> !adj_dir_o);

  assert_write_blocks_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i || frq_we_i) |=> !adj_pulse_o);

  assert_acc_below_ival_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == '0) || (acc_i < {1'b0, ival_i}));
endmodule

bind fadj_pulser fadj_pulser_chk #(.IVAL_W(IVAL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .frq_we_i    (frq_we_i),
  .adj_pulse_o (adj_pulse_o),
  .adj_dir_o   (adj_dir_o),
  .en_i        (en_q),
  .ival_i      (ival_q),
  .acc_i       (acc_q)
);

// File: tb/fadj_pulser_bench.sv
`timescale 1ns/1ps
module fadj_pulser_bench;
  localparam int unsigned IVAL_W = 30;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [1:0]      cfg_wdata = '0;
  logic            frq_we = 1'b0;
  logic [IVAL_W:0] frq_wdata = '0;
  logic            adj_pulse_o, adj_dir_o;
  int              n_chk = 0;
  int              n_fail = 0;

  always #5 clk = ~clk;

  fadj_pulser #(.IVAL_W(IVAL_W), .CLK_PERIOD_PS(10000)) u_fadj_pulser (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (cfg_wdata),
    .frq_we_i    (frq_we),
    .frq_wdata_i (frq_wdata),
    .adj_pulse_o (adj_pulse_o),
    .adj_dir_o   (adj_dir_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic en, input logic dir);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = {dir, en};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_frq(input logic unit, input int unsigned ival);
    @(negedge clk);
    frq_we = 1'b1; frq_wdata = {unit, ival[IVAL_W-1:0]};
    @(negedge clk);
    frq_we = 1'b0;
  endtask

  // sample k is taken at the falling edge after the k-th rising edge past the last write
  task automatic run_win(input int n, input logic exp_dir, output int cnt,
                         output int first, output int second, output int dir_bad);
    cnt = 0; first = -1; second = -1; dir_bad = 0;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (adj_pulse_o) begin
        cnt++;
        if (first < 0) first = k;
        else if (second < 0) second = k;
        if (adj_dir_o !== exp_dir) dir_bad++;
      end else if (adj_dir_o !== 1'b0) begin
        dir_bad++;
      end
    end
  endtask

  task automatic t_reset();
    int c, f, s, d;
    chk("R1 pulse after reset", int'(adj_pulse_o), 0);
    chk("R1 dir after reset", int'(adj_dir_o), 0);
    run_win(10, 1'b0, c, f, s, d);
    chk("R1 no pulses before enable", c, 0);
  endtask

  task automatic t_ps_basic();
    int c, f, s, d;
    wr_frq(1'b0, 50000);
    wr_cfg(1'b1, 1'b0);
    run_win(20, 1'b0, c, f, s, d);
    chk("R4 first pulse cycle", f, 5);
    chk("R4 second pulse cycle", s, 10);
    chk("R4 pulse count", c, 4);
    chk("R7 dir low when adding", d, 0);
  endtask

  task automatic t_remainder();
    int c, f, s, d;
    wr_cfg(1'b0, 1'b0);
    wr_frq(1'b0, 25000);
    wr_cfg(1'b1, 1'b0);
    run_win(15, 1'b0, c, f, s, d);
    chk("R5 first pulse cycle", f, 3);
    chk("R5 second pulse cycle", s, 5);
    chk("R5 pulse count", c, 6);
  endtask

  task automatic t_ns();
    int c, f, s, d;
    wr_frq(1'b1, 40);
    run_win(40, 1'b0, c, f, s, d);
    chk("R6 R3 ns first pulse", f, 4);
    chk("R6 R3 ns pulse count", c, 10);
  endtask

  task automatic t_dir();
    int c, f, s, d;
    wr_cfg(1'b1, 1'b1);
    run_win(40, 1'b1, c, f, s, d);
    chk("R7 pulses while dropping", c, 10);
    chk("R7 dir mismatches", d, 0);
  endtask

  task automatic t_restart();
    int c, f, s, d;
    wr_frq(1'b0, 50000);
    run_win(3, 1'b1, c, f, s, d);
    chk("R8 no pulse before rewrite", c, 0);
    wr_frq(1'b0, 50000);
    run_win(6, 1'b1, c, f, s, d);
    chk("R8 pulse a full interval after rewrite", f, 5);
  endtask

  task automatic t_zero();
    int c, f, s, d;
    wr_frq(1'b0, 0);
    run_win(30, 1'b1, c, f, s, d);
    chk("R9 zero interval pulse count", c, 0);
  endtask

  task automatic t_small();
    int c, f, s, d;
    wr_frq(1'b0, 7000);
    run_win(10, 1'b1, c, f, s, d);
    chk("R10 pulse every cycle", c, 10);
    chk("R10 first pulse cycle", f, 1);
  endtask

  task automatic t_disable();
    int c, f, s, d;
    wr_frq(1'b0, 20000);
    wr_cfg(1'b0, 1'b0);
    run_win(30, 1'b0, c, f, s, d);
    chk("R2 disabled pulse count", c, 0);
    chk("R2 disabled dir level", d, 0);
    wr_cfg(1'b1, 1'b0);
    run_win(10, 1'b0, c, f, s, d);
    chk("R2 re-enable first pulse", f, 2);
    chk("R2 re-enable pulse count", c, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ps_basic();
    t_remainder();
    t_ns();
    t_dir();
    t_restart();
    t_zero();
    t_small();
    t_disable();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule